// File: doc/BRIEF.md
# Camera Sensor Bring-Up Sequencer

This block brings an image sensor from cold to configured. It powers the sensor and holds its reset pin asserted for a fixed time. After reset is released it waits for the control bus to settle. It then reads a 16-bit identity from the sensor, and only if that identity matches the expected value does it read a revision word and write an initialisation table into the sensor. Each bus transfer is handed to an external serial control-bus master through a one-cycle request and a one-cycle done pulse. The sequencer only builds the requests; it does not generate the bus waveforms.

Because boards wire the sensor's power switch and reset pin with different polarities, a two-bit level setting picks the active level of each pin. Changing that setting at run time re-applies power and repeats the reset pulse, and the whole bring-up runs again. A power-down input returns the pins to their inactive levels and releases the bus lines. The initialisation table is a fixed list of address/value pairs. One reserved address turns an entry into a delay measured in milliseconds, and every delay is timed by a millisecond tick derived from the system clock.

The sequencer is a state machine. It starts in BOOT while reset is applied. OFF is the powered-down state. PWR_RST holds the sensor reset and SETTLE waits for the bus. RD_REQ and RD_WAIT perform the four identity and revision reads, and ID_CHECK compares the identity. TBL_FETCH, TBL_WR, TBL_WAIT and TBL_DELAY walk through the table. FIN lasts one cycle and leads to IDLE on success; FAIL is entered on an identity mismatch. The transitions are:
- BOOT goes to PWR_RST.
- OFF goes to PWR_RST once power-down is released.
- PWR_RST goes to SETTLE when its timer expires.
- SETTLE goes to RD_REQ when its timer expires.
- RD_REQ goes to RD_WAIT.
- RD_WAIT, on done, goes to RD_REQ, to ID_CHECK after the second read, or to TBL_FETCH after the fourth.
- ID_CHECK goes to RD_REQ on a match and to FAIL on a mismatch.
- TBL_FETCH goes to TBL_DELAY for a delay entry and to TBL_WR otherwise.
- TBL_WR goes to TBL_WAIT.
- TBL_WAIT on done, and TBL_DELAY on timer expiry, go to TBL_FETCH, or to FIN after the last entry.
- FIN goes to IDLE.
- Any state goes to OFF while power-down is high.
- Any state other than BOOT and OFF goes to PWR_RST when the level setting changes.

Top module: `cam_bringup_seq`

## Requirements
- R1: While rst_n is low, bus_req, bus_oe, seq_done, seq_pass and seq_fail are 0, pwr_en is 1 and sen_rst is 0 (the inactive levels of setting 00).
- R2: level[0]=1 makes pwr_en active-high and level[0]=0 makes it active-low. level[1]=1 makes sen_rst active-low (driven 0 while asserted) and level[1]=0 makes it active-high. Power is active whenever reset is asserted.
- R3: After rst_n is released, sen_rst is asserted for exactly RESET_MS*CLK_PER_MS consecutive cycles, as a single pulse with no bus request during it.
- R4: The first read request appears in the cycle after SETTLE_MS*CLK_PER_MS settle cycles, which follow the last reset cycle.
- R5: Four reads (bus_rd=1) are issued in the order 0x1C, 0x1D, 0x0A, 0x0B. Each is issued only after the previous done pulse.
- R6: ident is {data from 0x1C, data from 0x1D} and revision is {data from 0x0A, data from 0x0B}.
- R7: If ident differs from ID_EXPECT (0x7FA2), seq_fail stays high, only the two identity reads are issued and no write is issued.
- R8: Table writes (bus_rd=0) are issued in this order as addr/data: 12/80, 11/80, 3B/09, 13/E5, 15/20, 3A/0D. Each waits for the previous done pulse.
- R9: The table holds delay entries FF/0A (10 ms) after entry 12/80 and FF/02 (2 ms) after entry 3B/09. A delay entry is not written and adds value*CLK_PER_MS+1 cycles before the next request. Back-to-back writes start the cycle after the fetch that follows done.
- R10: seq_done pulses for exactly one cycle, one cycle after the done of the last table write; seq_pass then stays high.
- R11: A change of level re-asserts sen_rst for RESET_MS*CLK_PER_MS cycles and reruns the whole bring-up. Writing the same level causes no reset and no bus request.
- R12: While pwr_down is high, pwr_en and sen_rst sit at their inactive levels, bus_oe is 0 and no request is issued. Releasing pwr_down reruns the bring-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level | input | 2 | Bit 0: power pin polarity; bit 1: reset pin polarity |
| pwr_down | input | 1 | Hold sensor powered down |
| pwr_en | output | 1 | Sensor power-enable pin |
| sen_rst | output | 1 | Sensor reset pin |
| bus_oe | output | 1 | Drive the control bus lines (0 = release to inputs) |
| bus_req | output | 1 | One-cycle transfer request to the bus master |
| bus_rd | output | 1 | 1 = read, 0 = write, valid with bus_req |
| bus_addr | output | 8 | Sensor register address |
| bus_wdata | output | 8 | Write data |
| bus_done | input | 1 | One-cycle completion pulse from the bus master |
| bus_rdata | input | 8 | Read data, valid with bus_done |
| seq_done | output | 1 | One-cycle pulse when configuration completes |
| seq_pass | output | 1 | Configuration completed successfully |
| seq_fail | output | 1 | Identity check failed |
| ident | output | 16 | Identity word read from the sensor |
| revision | output | 16 | Revision word read from the sensor |

## Verification
Every output is a decode of the state register, so a result appears in the cycle after the clock edge that takes the triggering input. A done pulse seen by the bench therefore shows up as a request one cycle later for a plain write, and value*CLK_PER_MS+2 cycles later across a delay entry. The bench runs with CLK_PER_MS=4 and stamps each request, done pulse and reset-pin cycle with a cycle counter sampled on the falling edge. It compares the differences against these counts: 400 reset cycles, a settle gap of 41 and a completion pulse in the same sample as the last done. Stimulus changes are driven just after a falling edge, so each one takes effect at the next rising edge.

// File: rtl/cam_seq_pkg.sv
package cam_seq_pkg;

    typedef enum logic [3:0] {
        S_BOOT,
        S_OFF,
        S_PWR_RST,
        S_SETTLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_ID_CHECK,
        S_TBL_FETCH,
        S_TBL_WR,
        S_TBL_WAIT,
        S_TBL_DELAY,
        S_FIN,
        S_IDLE,
        S_FAIL
    } seq_state_t;

    localparam int TBL_LEN = 8;
    localparam int MS_W    = 8;
    localparam logic [7:0] DELAY_MARK = 8'hFF;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } tbl_entry_t;

    // Register order for the identity and revision reads
    function automatic logic [7:0] id_reg_addr(input logic [1:0] k);
        case (k)
            2'd0:    return 8'h1C;
            2'd1:    return 8'h1D;
            2'd2:    return 8'h0A;
            default: return 8'h0B;
        endcase
    endfunction

endpackage

// File: rtl/cam_ms_timer.sv
module cam_ms_timer #(
    parameter int CLK_PER_MS = 250000,
    parameter int MS_W       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] ms,
    output logic            expire
);
    localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

    logic             busy;
    logic [MS_W-1:0]  ms_left;
    logic [PRE_W-1:0] pre;
    logic             at_tick;

    assign at_tick = (pre == PRE_LAST);
    assign expire  = busy && ((ms_left == '0) ||
                              (ms_left == MS_W'(1) && at_tick));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            ms_left <= '0;
            pre     <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            ms_left <= ms;
            pre     <= '0;
        end else if (busy) begin
            if (expire) begin
                busy <= 1'b0;
            end else if (at_tick) begin
                pre     <= '0;
                ms_left <= ms_left - MS_W'(1);
            end else begin
                pre <= pre + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/cam_init_rom.sv
module cam_init_rom
    import cam_seq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    output tbl_entry_t       entry
);
    always_comb begin
        case (int'(idx))
            0:       entry = '{addr: 8'h12, data: 8'h80};  // soft reset
            1:       entry = '{addr: DELAY_MARK, data: 8'd10};
            2:       entry = '{addr: 8'h11, data: 8'h80};
            3:       entry = '{addr: 8'h3B, data: 8'h09};
            4:       entry = '{addr: DELAY_MARK, data: 8'd2};
            5:       entry = '{addr: 8'h13, data: 8'hE5};
            6:       entry = '{addr: 8'h15, data: 8'h20};
            7:       entry = '{addr: 8'h3A, data: 8'h0D};
            default: entry = '{addr: DELAY_MARK, data: 8'd0};
        endcase
    end
endmodule

// File: rtl/cam_bringup_seq.sv
module cam_bringup_seq
    import cam_seq_pkg::*;
#(
    parameter int          CLK_PER_MS = 250000,
    parameter int          RESET_MS   = 100,
    parameter int          SETTLE_MS  = 10,
    parameter logic [15:0] ID_EXPECT  = 16'h7FA2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  level,
    input  logic        pwr_down,
    output logic        pwr_en,
    output logic        sen_rst,
    output logic        bus_oe,
    output logic        bus_req,
    output logic        bus_rd,
    output logic [7:0]  bus_addr,
    output logic [7:0]  bus_wdata,
    input  logic        bus_done,
    input  logic [7:0]  bus_rdata,
    output logic        seq_done,
    output logic        seq_pass,
    output logic        seq_fail,
    output logic [15:0] ident,
    output logic [15:0] revision
);
    localparam int IDX_W = $clog2(TBL_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TBL_LEN - 1);

    seq_state_t       state, nxt;
    logic [1:0]       level_q;
    logic [1:0]       rd_idx;
    logic [IDX_W-1:0] tbl_idx;
    tbl_entry_t       entry;
    logic             tmr_load, tmr_expire;
    logic [MS_W-1:0]  tmr_ms;
    logic             lvl_chg;
    logic             pwr_on, rst_on;

    cam_ms_timer #(
        .CLK_PER_MS(CLK_PER_MS),
        .MS_W      (MS_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .ms    (tmr_ms),
        .expire(tmr_expire)
    );

    cam_init_rom #(.IDX_W(IDX_W)) u_rom (
        .idx  (tbl_idx),
        .entry(entry)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_BOOT;
            level_q <= 2'b00;
        end else begin
            state   <= nxt;
            level_q <= level;
        end
    end

    // Next state and timer control
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_ms   = '0;
        lvl_chg  = (level != level_q) && (state != S_BOOT) && (state != S_OFF);
        if (pwr_down) begin
            nxt = S_OFF;
        end else if (lvl_chg || state == S_BOOT || state == S_OFF) begin
            nxt      = S_PWR_RST;
            tmr_load = 1'b1;
            tmr_ms   = MS_W'(RESET_MS);
        end else begin
            unique case (state)
                S_PWR_RST: if (tmr_expire) begin
                    nxt      = S_SETTLE;
                    tmr_load = 1'b1;
                    tmr_ms   = MS_W'(SETTLE_MS);
                end
                S_SETTLE:  if (tmr_expire) nxt = S_RD_REQ;
                S_RD_REQ:  nxt = S_RD_WAIT;
                S_RD_WAIT: if (bus_done) begin
                    if (rd_idx == 2'd1)      nxt = S_ID_CHECK;
                    else if (rd_idx == 2'd3) nxt = S_TBL_FETCH;
                    else                     nxt = S_RD_REQ;
                end
                S_ID_CHECK: nxt = (ident == ID_EXPECT) ? S_RD_REQ : S_FAIL;
                S_TBL_FETCH: begin
                    if (entry.addr == DELAY_MARK) begin
                        nxt      = S_TBL_DELAY;
                        tmr_load = 1'b1;
                        tmr_ms   = MS_W'(entry.data);
                    end else begin
                        nxt = S_TBL_WR;
                    end
                end
                S_TBL_WR:   nxt = S_TBL_WAIT;
                S_TBL_WAIT: if (bus_done)
                    nxt = (tbl_idx == IDX_LAST) ? S_FIN : S_TBL_FETCH;
                S_TBL_DELAY: if (tmr_expire)
                    nxt = (tbl_idx == IDX_LAST) ? S_FIN : S_TBL_FETCH;
                S_FIN:      nxt = S_IDLE;
                default:    nxt = state;
            endcase
        end
    end

    // Datapath: read indices, table index, captured words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_idx   <= '0;
            tbl_idx  <= '0;
            ident    <= '0;
            revision <= '0;
        end else if (state == S_PWR_RST) begin
            rd_idx   <= '0;
            tbl_idx  <= '0;
            ident    <= '0;
            revision <= '0;
        end else begin
            if (state == S_RD_WAIT && bus_done) begin
                rd_idx <= rd_idx + 2'd1;
                case (rd_idx)
                    2'd0: ident[15:8]    <= bus_rdata;
                    2'd1: ident[7:0]     <= bus_rdata;
                    2'd2: revision[15:8] <= bus_rdata;
                    default: revision[7:0] <= bus_rdata;
                endcase
            end
            if ((state == S_TBL_WAIT && bus_done) ||
                (state == S_TBL_DELAY && tmr_expire)) begin
                tbl_idx <= tbl_idx + IDX_W'(1);
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        pwr_on    = (state != S_BOOT) && (state != S_OFF);
        rst_on    = (state == S_PWR_RST);
        pwr_en    = pwr_on ? level_q[0] : ~level_q[0];
        sen_rst   = rst_on ? ~level_q[1] : level_q[1];
        bus_oe    = pwr_on && !rst_on;
        bus_req   = (state == S_RD_REQ) || (state == S_TBL_WR);
        bus_rd    = (state == S_RD_REQ);
        bus_addr  = 8'h00;
        bus_wdata = 8'h00;
        if (state == S_RD_REQ) begin
            bus_addr = id_reg_addr(rd_idx);
        end else if (state == S_TBL_WR) begin
            bus_addr  = entry.addr;
            bus_wdata = entry.data;
        end
        seq_done = (state == S_FIN);
        seq_pass = (state == S_FIN) || (state == S_IDLE);
        seq_fail = (state == S_FAIL);
    end
endmodule

// File: rtl/cam_bringup_seq_chk.sv
module cam_bringup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] level,
    input logic       pwr_down,
    input logic       rst_on,
    input logic       bus_oe,
    input logic       bus_req,
    input logic       seq_done,
    input logic       seq_pass,
    input logic       seq_fail
);
    // R4: no request in the first cycle after reset release
    p_settle_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_on) |-> !bus_req);

    // R8: each request lasts one cycle
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> !bus_req);

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R10: pass holds and the bus stays quiet while nothing changes
    p_pass_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_pass && !seq_done && !pwr_down && level == $past(level))
        |=> (seq_pass && !bus_req));

    // R7: failure is sticky and silent
    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fail && !pwr_down && level == $past(level))
        |=> (seq_fail && !bus_req && !seq_pass));

    // R12: power-down releases the bus and stops traffic
    p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!bus_oe && !bus_req && !seq_pass && !rst_on));
endmodule

bind cam_bringup_seq cam_bringup_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (level),
    .pwr_down(pwr_down),
    .rst_on  (rst_on),
    .bus_oe  (bus_oe),
    .bus_req (bus_req),
    .seq_done(seq_done),
    .seq_pass(seq_pass),
    .seq_fail(seq_fail)
);

// File: tb/tb_cam_bringup_seq.sv
module tb_cam_bringup_seq;
    localparam int CPM    = 4;
    localparam int RST_MS = 100;
    localparam int SET_MS = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  level;
    logic        pwr_down;
    logic        pwr_en, sen_rst, bus_oe, bus_req, bus_rd;
    logic [7:0]  bus_addr, bus_wdata;
    logic        bus_done;
    logic [7:0]  bus_rdata;
    logic        seq_done, seq_pass, seq_fail;
    logic [15:0] ident, revision;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] m_id, m_rev;
    logic        log_clr = 1'b0;

    // monitor logs
    int         cyc = 0;
    int         nreq, ndone, done_cnt, done_at;
    int         rst_cnt, rst_starts, last_rst_cyc;
    bit         prev_act, act, pwr_at_rst;
    logic [7:0] r_addr [16];
    logic [7:0] r_data [16];
    logic       r_rd   [16];
    int         r_cyc  [16];
    int         d_cyc  [16];

    always #2 clk = ~clk;

    cam_bringup_seq #(.CLK_PER_MS(CPM)) dut (
        .clk(clk), .rst_n(rst_n), .level(level), .pwr_down(pwr_down),
        .pwr_en(pwr_en), .sen_rst(sen_rst), .bus_oe(bus_oe),
        .bus_req(bus_req), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .seq_done(seq_done), .seq_pass(seq_pass), .seq_fail(seq_fail),
        .ident(ident), .revision(revision)
    );

    function automatic logic [7:0] tb_addr(input int e);
        logic [7:0] a [8] = '{8'h12, 8'hFF, 8'h11, 8'h3B, 8'hFF, 8'h13, 8'h15, 8'h3A};
        return a[e];
    endfunction

    function automatic logic [7:0] tb_data(input int e);
        logic [7:0] d [8] = '{8'h80, 8'h0A, 8'h80, 8'h09, 8'h02, 8'hE5, 8'h20, 8'h0D};
        return d[e];
    endfunction

    function automatic logic [7:0] tb_rd_addr(input int k);
        logic [7:0] a [4] = '{8'h1C, 8'h1D, 8'h0A, 8'h0B};
        return a[k];
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h1C:   return m_id[15:8];
            8'h1D:   return m_id[7:0];
            8'h0A:   return m_rev[15:8];
            8'h0B:   return m_rev[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act_v, input longint exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act_v, exp_v);
        end
    endtask

    // monitor on falling edge
    always @(negedge clk) begin
        if (log_clr) begin
            nreq = 0; ndone = 0; done_cnt = 0; done_at = -1;
            rst_cnt = 0; rst_starts = 0; last_rst_cyc = -1;
            prev_act = 1'b0; pwr_at_rst = 1'b0;
        end else begin
            cyc++;
            act = rst_n && (sen_rst == ~level[1]);
            if (act) begin
                rst_cnt++;
                last_rst_cyc = cyc;
                if (!prev_act) begin
                    rst_starts++;
                    pwr_at_rst = pwr_en;
                end
            end
            prev_act = act;
            if (bus_req && nreq < 16) begin
                r_addr[nreq] = bus_addr; r_data[nreq] = bus_wdata;
                r_rd[nreq] = bus_rd; r_cyc[nreq] = cyc; nreq++;
            end
            if (bus_done && ndone < 16) begin
                d_cyc[ndone] = cyc; ndone++;
            end
            if (seq_done) begin
                done_cnt++; done_at = cyc;
            end
        end
    end

    // bus master model with random latency
    initial begin
        int cnt = 0;
        logic [7:0] a = 8'h00;
        bus_done  = 1'b0;
        bus_rdata = 8'h00;
        forever begin
            @(negedge clk);
            #1;
            bus_done = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    bus_done  = 1'b1;
                    bus_rdata = model_read(a);
                end
            end else if (bus_req) begin
                a   = bus_addr;
                cnt = int'($urandom_range(1, 5));
            end
        end
    end

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary_and_end();
    end

    task automatic clear_logs();
        @(negedge clk); #1 log_clr = 1'b1;
        @(negedge clk); #1 log_clr = 1'b0;
    endtask

    task automatic wait_end();
        int k = 0;
        while (!(done_cnt > 0 || seq_fail) && k < 5000) begin
            @(negedge clk);
            k++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_full(input logic [1:0] lv);
        int ri = 4;
        int eg = 1;
        chk(rst_cnt == RST_MS * CPM, "R3 reset width", rst_cnt, RST_MS * CPM);
        chk(rst_starts == 1, "R3 single pulse", rst_starts, 1);
        chk(pwr_at_rst == lv[0], "R2 power active level", pwr_at_rst, lv[0]);
        chk(nreq == 10, "R8 request count", nreq, 10);
        chk(r_cyc[0] - last_rst_cyc == SET_MS * CPM + 1, "R4 settle gap",
            r_cyc[0] - last_rst_cyc, SET_MS * CPM + 1);
        for (int k = 0; k < 4; k++)
            chk(r_rd[k] == 1'b1 && r_addr[k] == tb_rd_addr(k), "R5 read order",
                r_addr[k], tb_rd_addr(k));
        chk(ident == 16'h7FA2, "R6 ident", ident, 16'h7FA2);
        chk(revision == m_rev, "R6 revision", revision, m_rev);
        for (int e = 0; e < 8; e++) begin
            if (tb_addr(e) == 8'hFF) begin
                eg += int'(tb_data(e)) * CPM + 1;
            end else begin
                chk(r_rd[ri] == 1'b0 && r_addr[ri] == tb_addr(e) && r_data[ri] == tb_data(e),
                    "R8 table write", {r_addr[ri], r_data[ri]}, {tb_addr(e), tb_data(e)});
                chk(r_cyc[ri] - d_cyc[ri-1] == eg, "R9 request gap",
                    r_cyc[ri] - d_cyc[ri-1], eg);
                ri++;
                eg = 1;
            end
        end
        chk(done_cnt == 1, "R10 done pulses", done_cnt, 1);
        chk(done_at == d_cyc[9], "R10 done timing", done_at, d_cyc[9]);
        chk(seq_pass && !seq_fail, "R10 pass flag", {seq_pass, seq_fail}, 2'b10);
        chk(pwr_en == lv[0] && sen_rst == lv[1], "R2 idle pin levels",
            {pwr_en, sen_rst}, {lv[0], lv[1]});
    endtask

    initial begin
        logic [1:0] cur;
        void'($urandom(32'd24681));
        rst_n    = 1'b0;
        pwr_down = 1'b0;
        level    = 2'b01;
        cur      = 2'b01;
        m_id     = 16'h7FA2;
        m_rev    = 16'($urandom);
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(pwr_en == 1'b1 && sen_rst == 1'b0, "R1 pins in reset", {pwr_en, sen_rst}, 2'b10);
        chk(!bus_req && !bus_oe, "R1 bus idle in reset", {bus_req, bus_oe}, 0);
        chk(!seq_done && !seq_pass && !seq_fail, "R1 status in reset",
            {seq_done, seq_pass, seq_fail}, 0);

        clear_logs();
        rst_n = 1'b1;
        wait_end();
        check_full(cur);

        // R11 unchanged setting does nothing
        clear_logs();
        level = cur;
        repeat (60) @(negedge clk);
        chk(rst_cnt == 0 && nreq == 0, "R11 same level no effect", rst_cnt + nreq, 0);
        chk(seq_pass == 1'b1, "R11 pass kept", seq_pass, 1);

        // R11 changed setting reruns bring-up (random levels, random latencies)
        for (int it = 0; it < 3; it++) begin
            logic [1:0] nl;
            do nl = 2'($urandom) ; while (nl == cur);
            m_rev = 16'($urandom);
            clear_logs();
            level = nl;
            cur   = nl;
            wait_end();
            check_full(cur);
        end

        // R7 identity mismatch
        do m_id = 16'($urandom); while (m_id == 16'h7FA2);
        clear_logs();
        cur   = cur ^ 2'b10;
        level = cur;
        wait_end();
        chk(seq_fail == 1'b1 && seq_pass == 1'b0, "R7 fail flag", {seq_fail, seq_pass}, 2'b10);
        chk(nreq == 2, "R7 only identity reads", nreq, 2);
        chk(done_cnt == 0, "R7 no done", done_cnt, 0);
        chk(ident == m_id, "R6 ident on mismatch", ident, m_id);
        repeat (30) @(negedge clk);
        chk(nreq == 2 && seq_fail, "R7 stays failed", nreq, 2);

        // R12 power-down
        @(negedge clk); #1 pwr_down = 1'b1;
        repeat (3) @(negedge clk);
        chk(pwr_en == ~cur[0] && sen_rst == cur[1], "R12 pins inactive",
            {pwr_en, sen_rst}, {~cur[0], cur[1]});
        chk(bus_oe == 1'b0 && !bus_req, "R12 bus released", {bus_oe, bus_req}, 0);
        chk(!seq_fail && !seq_pass, "R12 status cleared", {seq_fail, seq_pass}, 0);
        m_id = 16'h7FA2;
        m_rev = 16'($urandom);
        clear_logs();
        pwr_down = 1'b0;
        wait_end();
        check_full(cur);

        summary_and_end();
    end
endmodule